// File: doc/BRIEF.md
# ADC conversion control and result lock

This block is the digital sequencer that sits next to a successive-approximation converter core. The core is represented only by a one-cycle done pulse and a 12-bit result word; the block tells it when to begin with a one-cycle start pulse. Software drives the block through a small byte-wide register port. A write to the control register picks a channel, single or continuous operation and interrupt enable. A configuration register picks the result width (8, 10 or 12 bits), whether a compare outcome gates the result, and whether conversions wait for a hardware trigger.

Each accepted result is right-justified to the selected width and copied into a high/low byte pair. The copy raises a complete flag and, if enabled at that moment, an interrupt. A byte pair that is half read is protected. Once the high byte has been read in 10-bit or 12-bit width, a later result is thrown away, the flag stays as it was and the converter is restarted. This lasts until the low byte is read. A control write aborts whatever is in flight. Writing the all-ones channel code parks the block in idle.

Register map: address 0 control, address 1 configuration, address 2 result high byte, address 3 result low byte. Read data is combinational from the address; read side effects take place at the clock edge of a cycle with `reg_rd` high.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset `start_conv` and `irq` are low, control reads 0x1F (channel field bits [4:0] all ones, all other bits zero), and configuration and both result bytes read 0x00.
- R2: A write to address 0 whose channel field [4:0] is not 0x1F, with hardware trigger select (configuration bit 7) clear, makes `start_conv` high for exactly the one cycle after the write edge.
- R3: With configuration bit 7 set, a control write arms the block without starting it. The next `hw_trigger` pulse gives `start_conv` the cycle after it. Triggers while idle or while a conversion is running are ignored. After a single conversion completes, the block is armed again.
- R4: A `conv_done` pulse while a conversion runs, with no lock and no failed compare, stores the result the cycle after. The stored value is the result shifted right by 4 in width mode 0 (8-bit), by 2 in mode 1 (10-bit), and unshifted in mode 2 (12-bit); the mode sits in configuration bits [1:0]. Address 2 reads stored bits [11:8] zero-extended, address 3 reads bits [7:0], and control bit 7 (complete flag) becomes 1.
- R5: With control bit 5 (continuous) set, each completed conversion gives a new `start_conv` the cycle after `conv_done`; with it clear, no new start follows a stored result.
- R6: `irq` rises together with the complete flag only if control bit 6 (interrupt enable) was 1 at that edge, stays high across other reads, and falls after a read of address 3.
- R7: In modes 1 and 2, a read of address 2 sets a lock. While locked, a `conv_done` leaves both result bytes and the flag unchanged and gives `start_conv` the next cycle even in single mode. A read of address 3 clears the lock and the complete flag.
- R8: In mode 0 a read of address 2 sets no lock, so the next result is stored normally.
- R9: With configuration bit 2 (compare enable) set and `cmp_true` low at `conv_done`, nothing is stored and the flag is not set. A single conversion then stops, even while locked, with no new `start_conv`. A continuous conversion restarts.
- R10: A control write aborts a running conversion: a `conv_done` that follows a write of channel 0x1F stores nothing and no `start_conv` follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the edge) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| hw_trigger | input | 1 | Hardware start request pulse |
| start_conv | output | 1 | One-cycle start request to the converter core |
| conv_done | input | 1 | One-cycle completion pulse from the core |
| conv_result | input | 12 | Raw result word, valid with `conv_done` |
| cmp_true | input | 1 | Compare outcome, valid with `conv_done` |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
`start_conv` is due one edge after the write, trigger or done pulse that causes it. The flag, result bytes and `irq` change one edge after `conv_done`. Lock and flag changes from a read take effect at the read's own edge, while `reg_rdata` is valid in the same cycle as the address. The bench drives every stimulus for one cycle starting at a falling edge. It samples `start_conv` and `irq` at the next falling edge, after the single register stage, and reads registers through the port afterwards. Random rounds compute the expected lock, compare and store outcome with bench functions before the done pulse is given.

// File: rtl/adc_cc_pkg.sv
// Shared types and register addresses for the conversion controller.
// Assumes a 2-bit register address space.
package adc_cc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_TRIG = 2'd1,
        ST_BUSY      = 2'd2
    } seq_state_t;

    localparam logic [1:0] MODE_8  = 2'd0;
    localparam logic [1:0] MODE_10 = 2'd1;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_CFG  = 2'd1;
    localparam logic [1:0] ADR_RHI  = 2'd2;
    localparam logic [1:0] ADR_RLO  = 2'd3;

endpackage

// File: rtl/adc_cc_regs.sv
// Control and configuration registers plus the read multiplexer.
// Assumes CHAN_W + 2 < DATA_W and RES_W - DATA_W <= DATA_W; the flag
// occupies the top control bit, the trigger select the top config bit.
module adc_cc_regs
    import adc_cc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHAN_W = 5,
    parameter int RES_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              done_flag,
    input  logic [RES_W-1:0]  res_val,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ctrl_wr,
    output logic              wr_disable,
    output logic              cont,
    output logic              ie,
    output logic              hw_sel,
    output logic              cmp_en,
    output logic [1:0]        mode
);
    localparam int CONT_BIT = CHAN_W;
    localparam int IE_BIT   = CHAN_W + 1;
    localparam int FLAG_BIT = DATA_W - 1;
    localparam int HI_W     = RES_W - DATA_W;

    logic [CHAN_W-1:0] chan_q;
    logic              cfg_wr;

    assign ctrl_wr    = reg_wr && (reg_addr == ADR_CTRL);
    assign cfg_wr     = reg_wr && (reg_addr == ADR_CFG);
    assign wr_disable = &reg_wdata[CHAN_W-1:0];

    // Purpose: hold control fields, reset to the disabled channel code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '1;
            cont   <= 1'b0;
            ie     <= 1'b0;
        end else if (ctrl_wr) begin
            chan_q <= reg_wdata[CHAN_W-1:0];
            cont   <= reg_wdata[CONT_BIT];
            ie     <= reg_wdata[IE_BIT];
        end
    end

    // Purpose: hold configuration fields (width mode, compare, trigger select).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= MODE_8;
            cmp_en <= 1'b0;
            hw_sel <= 1'b0;
        end else if (cfg_wr) begin
            mode   <= reg_wdata[1:0];
            cmp_en <= reg_wdata[2];
            hw_sel <= reg_wdata[DATA_W-1];
        end
    end

    // Purpose: select read data from the addressed register.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[CHAN_W-1:0] = chan_q;
                reg_rdata[CONT_BIT]   = cont;
                reg_rdata[IE_BIT]     = ie;
                reg_rdata[FLAG_BIT]   = done_flag;
            end
            ADR_CFG: begin
                reg_rdata[1:0]        = mode;
                reg_rdata[2]          = cmp_en;
                reg_rdata[DATA_W-1]   = hw_sel;
            end
            ADR_RHI: reg_rdata[HI_W-1:0] = res_val[RES_W-1:DATA_W];
            default: reg_rdata = res_val[DATA_W-1:0];
        endcase
    end

endmodule

// File: rtl/adc_cc_seq.sv
// Conversion sequencer: decides when to request a conversion and whether
// a finished one may be stored. Assumes conv_done pulses only once per
// start request; a control write in the same cycle wins over conv_done.
module adc_cc_seq
    import adc_cc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_disable,
    input  logic hw_sel,
    input  logic cont,
    input  logic cmp_en,
    input  logic cmp_true,
    input  logic lock,
    input  logic hw_trigger,
    input  logic conv_done,
    output logic start_conv,
    output logic xfer,
    output logic busy
);
    seq_state_t state_q;
    seq_state_t stop_state;
    logic       cmp_fail;
    logic       done_ev;
    logic       restart;

    assign busy       = (state_q == ST_BUSY);
    assign cmp_fail   = cmp_en && !cmp_true;
    assign done_ev    = busy && conv_done && !ctrl_wr;
    assign xfer       = done_ev && !cmp_fail && !lock;
    assign restart    = cmp_fail ? cont : (lock || cont);
    assign stop_state = hw_sel ? ST_WAIT_TRIG : ST_IDLE;

    // Purpose: advance the sequencer and issue one-cycle start requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            start_conv <= 1'b0;
        end else begin
            start_conv <= 1'b0;
            if (ctrl_wr) begin
                if (wr_disable) begin
                    state_q <= ST_IDLE;
                end else if (hw_sel) begin
                    state_q <= ST_WAIT_TRIG;
                end else begin
                    state_q    <= ST_BUSY;
                    start_conv <= 1'b1;
                end
            end else begin
                case (state_q)
                    ST_WAIT_TRIG: begin
                        if (hw_trigger) begin
                            state_q    <= ST_BUSY;
                            start_conv <= 1'b1;
                        end
                    end
                    ST_BUSY: begin
                        if (done_ev) begin
                            if (restart) begin
                                start_conv <= 1'b1;
                            end else begin
                                state_q <= stop_state;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/adc_cc_result.sv
// Result byte pair, complete flag, read lock and interrupt latch.
// Assumes the lock is set only by high-byte reads in 10/12-bit width and
// that a store outranks a low-byte read clearing the flag in one cycle.
module adc_cc_result
    import adc_cc_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer,
    input  logic [RES_W-1:0] conv_result,
    input  logic [1:0]       mode,
    input  logic             ie,
    input  logic             rd_hi,
    input  logic             rd_lo,
    output logic [RES_W-1:0] res_val,
    output logic             done_flag,
    output logic             lock,
    output logic             irq
);
    localparam int SH_8  = RES_W - 8;
    localparam int SH_10 = RES_W - 10;

    logic [RES_W-1:0] justified;

    // Purpose: right-justify the raw word to the selected width.
    always_comb begin
        case (mode)
            MODE_8:  justified = conv_result >> SH_8;
            MODE_10: justified = conv_result >> SH_10;
            default: justified = conv_result;
        endcase
    end

    // Purpose: store accepted results and maintain flag and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_val   <= '0;
            done_flag <= 1'b0;
            irq       <= 1'b0;
        end else if (xfer) begin
            res_val   <= justified;
            done_flag <= 1'b1;
            irq       <= irq || ie;
        end else if (rd_lo) begin
            done_flag <= 1'b0;
            irq       <= 1'b0;
        end
    end

    // Purpose: track a half-read byte pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock <= 1'b0;
        end else if (rd_lo) begin
            lock <= 1'b0;
        end else if (rd_hi && (mode != MODE_8)) begin
            lock <= 1'b1;
        end
    end

endmodule

// File: rtl/adc_conv_ctrl.sv
// Top of the conversion controller: wires registers, sequencer and result
// store. Assumes all inputs are synchronous to clk.
module adc_conv_ctrl
    import adc_cc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHAN_W = 5,
    parameter int RES_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              hw_trigger,
    output logic              start_conv,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              cmp_true,
    output logic              irq
);
    logic             ctrl_wr;
    logic             wr_disable;
    logic             cont;
    logic             ie;
    logic             hw_sel;
    logic             cmp_en;
    logic [1:0]       mode;
    logic             xfer;
    logic             busy;
    logic             lock;
    logic             done_flag;
    logic [RES_W-1:0] res_val;
    logic             rd_hi;
    logic             rd_lo;

    assign rd_hi = reg_rd && (reg_addr == ADR_RHI);
    assign rd_lo = reg_rd && (reg_addr == ADR_RLO);

    adc_cc_regs #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .RES_W(RES_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .done_flag  (done_flag),
        .res_val    (res_val),
        .reg_rdata  (reg_rdata),
        .ctrl_wr    (ctrl_wr),
        .wr_disable (wr_disable),
        .cont       (cont),
        .ie         (ie),
        .hw_sel     (hw_sel),
        .cmp_en     (cmp_en),
        .mode       (mode)
    );

    adc_cc_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .wr_disable (wr_disable),
        .hw_sel     (hw_sel),
        .cont       (cont),
        .cmp_en     (cmp_en),
        .cmp_true   (cmp_true),
        .lock       (lock),
        .hw_trigger (hw_trigger),
        .conv_done  (conv_done),
        .start_conv (start_conv),
        .xfer       (xfer),
        .busy       (busy)
    );

    adc_cc_result #(.RES_W(RES_W)) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer        (xfer),
        .conv_result (conv_result),
        .mode        (mode),
        .ie          (ie),
        .rd_hi       (rd_hi),
        .rd_lo       (rd_lo),
        .res_val     (res_val),
        .done_flag   (done_flag),
        .lock        (lock),
        .irq         (irq)
    );

endmodule

// File: rtl/adc_cc_chk.sv
// Property checker for the conversion controller, attached by bind.
// Assumes it observes the top module's internal nets named below.
module adc_cc_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             wr_disable,
    input logic             conv_done,
    input logic             cmp_en,
    input logic             cmp_true,
    input logic             busy,
    input logic             lock,
    input logic             ie,
    input logic             done_flag,
    input logic             irq,
    input logic             start_conv,
    input logic [RES_W-1:0] res_val
);
    // R4: the flag only rises after a done pulse of a running conversion
    a_r4_flag_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ($past(conv_done) && $past(busy)));

    // R6: interrupt only rises when enable was set at that edge
    a_r6_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ie));

    // R7: a locked pair keeps its stored value
    a_r7_locked_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(res_val));

    // R7: a blocked result forces a restart
    a_r7_block_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done && lock && !ctrl_wr && !(cmp_en && !cmp_true)) |=> start_conv);

    // R9: a failed compare never raises the flag
    a_r9_cmp_fail_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done && cmp_en && !cmp_true && !done_flag) |=> !done_flag);

    // R10: a disabling write never issues a start
    a_r10_disable_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_disable) |=> !start_conv);

endmodule

bind adc_conv_ctrl adc_cc_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .wr_disable (wr_disable),
    .conv_done  (conv_done),
    .cmp_en     (cmp_en),
    .cmp_true   (cmp_true),
    .busy       (busy),
    .lock       (lock),
    .ie         (ie),
    .done_flag  (done_flag),
    .irq        (irq),
    .start_conv (start_conv),
    .res_val    (res_val)
);

// File: tb/sim_adc_conv_ctrl.sv
// Self-checking bench: directed corner cases followed by seeded random rounds.
module sim_adc_conv_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        hw_trigger = 1'b0;
    logic        start_conv;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = 12'd0;
    logic        cmp_true = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [11:0] exp_store = 12'd0;
    logic [7:0]  d;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_conv_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_trigger(hw_trigger), .start_conv(start_conv), .conv_done(conv_done),
        .conv_result(conv_result), .cmp_true(cmp_true), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic conv(input logic [11:0] r, input logic ct);
        conv_done = 1'b1; conv_result = r; cmp_true = ct;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic trig();
        hw_trigger = 1'b1;
        @(negedge clk);
        hw_trigger = 1'b0;
    endtask

    function automatic logic [11:0] store_of(input logic [11:0] r, input logic [1:0] m);
        case (m)
            2'd0:    return r >> 4;
            2'd1:    return r >> 2;
            default: return r;
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 start_conv", 16'(start_conv), 16'h0);
        chk("R1 irq", 16'(irq), 16'h0);
        rd(2'd0, d); chk("R1 ctrl", 16'(d), 16'h1F);
        rd(2'd1, d); chk("R1 cfg", 16'(d), 16'h00);
        rd(2'd2, d); chk("R1 high", 16'(d), 16'h00);
        rd(2'd3, d); chk("R1 low", 16'(d), 16'h00);

        // R2 software start, R5 single stops, R4 store
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h01);
        chk("R2 start pulse", 16'(start_conv), 16'h1);
        @(negedge clk);
        chk("R2 pulse one cycle", 16'(start_conv), 16'h0);
        conv(12'hABC, 1'b1);
        chk("R5 single no restart", 16'(start_conv), 16'h0);
        chk("R6 no irq without enable", 16'(irq), 16'h0);
        rd(2'd0, d); chk("R4 flag set", 16'(d), 16'h81);
        rd(2'd2, d); chk("R4 high byte", 16'(d), 16'h0A);
        rd(2'd3, d); chk("R4 low byte", 16'(d), 16'hBC);
        rd(2'd0, d); chk("R7 low read clears flag", 16'(d), 16'h01);

        // R6 interrupt
        wr(2'd0, 8'h41);
        conv(12'h123, 1'b1);
        chk("R6 irq rises", 16'(irq), 16'h1);
        rd(2'd0, d); chk("R6 ctrl with flag", 16'(d), 16'hC1);
        chk("R6 irq held", 16'(irq), 16'h1);
        rd(2'd2, d); chk("R4 high 123", 16'(d), 16'h01);
        rd(2'd3, d); chk("R4 low 123", 16'(d), 16'h23);
        chk("R6 irq cleared", 16'(irq), 16'h0);

        // R7 lock in single mode
        wr(2'd0, 8'h01);
        rd(2'd2, d); chk("R7 old high", 16'(d), 16'h01);
        conv(12'h456, 1'b1);
        chk("R7 blocked restart", 16'(start_conv), 16'h1);
        rd(2'd0, d); chk("R7 no flag when blocked", 16'(d), 16'h01);
        rd(2'd3, d); chk("R7 low unchanged", 16'(d), 16'h23);
        conv(12'h456, 1'b1);
        chk("R7 unlocked store no restart", 16'(start_conv), 16'h0);
        rd(2'd2, d); chk("R7 high after unlock", 16'(d), 16'h04);
        rd(2'd3, d); chk("R7 low after unlock", 16'(d), 16'h56);

        // R8 no lock in 8-bit width
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h01);
        rd(2'd2, d);
        conv(12'hFE7, 1'b1);
        chk("R8 no restart", 16'(start_conv), 16'h0);
        rd(2'd0, d); chk("R8 stored despite high read", 16'(d), 16'h81);
        rd(2'd2, d); chk("R8 high zero", 16'(d), 16'h00);
        rd(2'd3, d); chk("R8 low", 16'(d), 16'hFE);

        // R9 compare false: single stops even when locked, continuous restarts
        wr(2'd1, 8'h06);
        wr(2'd0, 8'h01);
        rd(2'd2, d);
        conv(12'h111, 1'b0);
        chk("R9 single stops", 16'(start_conv), 16'h0);
        rd(2'd0, d); chk("R9 no flag", 16'(d), 16'h01);
        rd(2'd3, d); chk("R9 low unchanged", 16'(d), 16'hFE);
        wr(2'd0, 8'h21);
        conv(12'h222, 1'b0);
        chk("R9 continuous restarts", 16'(start_conv), 16'h1);
        rd(2'd0, d); chk("R9 continuous no flag", 16'(d), 16'h21);
        conv(12'h333, 1'b1);
        chk("R5 continuous restart", 16'(start_conv), 16'h1);
        rd(2'd0, d); chk("R5 flag", 16'(d), 16'hA1);
        rd(2'd2, d); chk("R5 high", 16'(d), 16'h03);
        rd(2'd3, d); chk("R5 low", 16'(d), 16'h33);

        // R10 abort with disabling write
        wr(2'd0, 8'h1F);
        chk("R10 no start", 16'(start_conv), 16'h0);
        conv(12'h777, 1'b1);
        chk("R10 no restart", 16'(start_conv), 16'h0);
        rd(2'd0, d); chk("R10 no flag", 16'(d), 16'h1F);
        rd(2'd3, d); chk("R10 low unchanged", 16'(d), 16'h33);

        // R3 hardware trigger
        wr(2'd1, 8'h82);
        trig();
        chk("R3 trigger ignored idle", 16'(start_conv), 16'h0);
        wr(2'd0, 8'h05);
        chk("R3 armed no start", 16'(start_conv), 16'h0);
        trig();
        chk("R3 trigger starts", 16'(start_conv), 16'h1);
        trig();
        chk("R3 trigger ignored busy", 16'(start_conv), 16'h0);
        conv(12'h5A5, 1'b1);
        chk("R3 single stops", 16'(start_conv), 16'h0);
        rd(2'd0, d); chk("R3 flag", 16'(d), 16'h85);
        rd(2'd2, d); chk("R3 high", 16'(d), 16'h05);
        rd(2'd3, d); chk("R3 low", 16'(d), 16'hA5);
        trig();
        chk("R3 rearmed", 16'(start_conv), 16'h1);
        exp_store = 12'h5A5;

        // Random rounds, software trigger, single mode
        for (int i = 0; i < 40; i++) begin
            logic [1:0]  m;
            logic        ce, ct, ien, dl, fl, blk, ok;
            logic [4:0]  ch;
            logic [11:0] r;
            string       tag;
            m   = 2'($urandom_range(0, 2));
            ce  = 1'($urandom_range(0, 1));
            ct  = 1'($urandom_range(0, 1));
            ien = 1'($urandom_range(0, 1));
            dl  = 1'($urandom_range(0, 1));
            ch  = 5'($urandom_range(0, 30));
            r   = 12'($urandom);
            fl  = ce && !ct;
            blk = !fl && dl && (m != 2'd0);
            ok  = !fl && !blk;
            if (fl)                      tag = "R9";
            else if (blk)                tag = "R7";
            else if (dl && m == 2'd0)    tag = "R8";
            else                         tag = "R4";
            rd(2'd3, d);
            wr(2'd1, {5'b0, ce, m});
            wr(2'd0, {1'b0, ien, 1'b0, ch});
            chk("R2 random start", 16'(start_conv), 16'h1);
            if (dl) rd(2'd2, d);
            conv(r, ct);
            chk({tag, " random restart"}, 16'(start_conv), 16'(blk));
            chk("R6 random irq", 16'(irq), 16'(ok && ien));
            if (ok) exp_store = store_of(r, m);
            rd(2'd0, d); chk({tag, " random ctrl"}, 16'(d), 16'({ok, ien, 1'b0, ch}));
            rd(2'd2, d); chk({tag, " random high"}, 16'(d), 16'({4'b0, exp_store[11:8]}));
            rd(2'd3, d); chk({tag, " random low"}, 16'(d), 16'(exp_store[7:0]));
        end

        finish_run();
    end

endmodule